// File: doc/BRIEF.md
# Vector Buffer Range Guard

This block sits between the address stage and the memory request port of a vector memory pipeline. A buffer load or store arrives with a per-lane execute mask, per-lane offsets and indices, an immediate offset, a scalar offset and a buffer description: stride, record count and a swizzle flag. For every lane the block forms the byte reach into the buffer and decides whether that lane falls outside the buffer. Lanes that fall outside are dropped from the request mask, so they cause no memory traffic and no fault.

On the return path a load's out-of-range lanes are written back as zero instead of returned data. Lanes whose execute bit is clear are never written. A load whose lanes all fall outside the buffer raises no request and still completes its writeback on its own. One load may be outstanding at a time.

Top module: `vbuf_range_guard`

## Requirements
- R1: One cycle after `in_valid`, `req_mask` equals the execute mask with every out-of-range lane cleared (bit i is lane i), and `req_valid` is high only in that cycle.
- R2: A lane's reach is `voff + inst_off + stride * vidx`, computed unsigned and without wrap. The lane is out of range when reach >= `records - scalar_off`.
- R3: The range check applies only when the stride is zero or swizzle is disabled. When the stride is nonzero and swizzle is enabled, no lane is flagged.
- R4: When the range check applies and `scalar_off` is greater than `records`, every lane is out of range.
- R5: When the request mask would be all zero, `req_valid` stays low. A store's out-of-range lanes never appear in `req_mask`.
- R6: One cycle after `rsp_valid`, `wb_valid` is high. Each enabled lane that was in range carries its returned word. Each enabled lane that was out of range carries zero.
- R7: `wb_en` equals the original execute mask of the load and is zero when `wb_valid` is low. Lanes whose execute bit is clear are never written, whatever their range result.
- R8: A load that issues with an all-zero request mask raises `wb_valid` two cycles after `in_valid`, with zero in every enabled lane.
- R9: After reset, `req_valid` and `wb_valid` are low.
- R10: Lane i of `req_off` (bits 32i+31..32i) is the low 32 bits of that lane's reach. Lane i of `req_wdata` is the store word of lane i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access presented this cycle |
| in_store | input | 1 | 1 = store, 0 = load |
| in_exec | input | LANES | Execute mask |
| in_voff | input | LANES*32 | Per-lane vector offsets |
| in_vidx | input | LANES*32 | Per-lane indices |
| in_wdata | input | LANES*32 | Per-lane store data |
| in_inst_off | input | 32 | Immediate offset |
| in_scalar_off | input | 32 | Scalar offset |
| in_stride | input | 32 | Descriptor stride |
| in_records | input | 32 | Descriptor record count |
| in_swz_en | input | 1 | Descriptor swizzle enable |
| req_valid | output | 1 | Memory request |
| req_store | output | 1 | Request is a store |
| req_mask | output | LANES | Lanes that access memory |
| req_off | output | LANES*32 | Per-lane buffer reach |
| req_wdata | output | LANES*32 | Per-lane store data |
| rsp_valid | input | 1 | Load data returned |
| rsp_rdata | input | LANES*32 | Returned per-lane data |
| wb_valid | output | 1 | Destination write |
| wb_en | output | LANES | Lanes written |
| wb_data | output | LANES*32 | Data written |

## Verification
The hardest situation to reach is the exact edge of the buffer, where one lane's reach equals the limit and its neighbour's is one below it. Random offsets almost never land there. Directed cases therefore compute the offsets backward from the record count and scalar offset. The same method builds a load whose every active lane lies outside the buffer, so the path that completes without a request is exercised. Random cases keep records, offsets and strides small, so both outcomes of the check occur often, and they toggle stride and swizzle so that the case with the check disabled is mixed in.

// File: rtl/vbg_pkg.sv
package vbg_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned SPAN_W = 2 * WORD_W;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [SPAN_W-1:0] span_t;
endpackage

// File: rtl/vbg_lane_check.sv
module vbg_lane_check
    import vbg_pkg::*;
(
    input  word_t voff,
    input  word_t vidx,
    input  word_t inst_off,
    input  word_t stride,
    input  span_t limit,
    input  logic  limit_neg,
    input  logic  chk_en,
    output logic  oob,
    output word_t reach_lo
);
    span_t reach;

    always_comb begin
        reach    = span_t'(voff) + span_t'(inst_off) + span_t'(stride) * span_t'(vidx);
        reach_lo = reach[WORD_W-1:0];
        oob      = chk_en && (limit_neg || (reach >= limit));
    end
endmodule

// File: rtl/vbg_issue_stage.sv
module vbg_issue_stage
    import vbg_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_store,
    input  logic [LANES-1:0]        in_exec,
    input  logic [LANES-1:0]        lane_oob,
    input  logic [LANES*WORD_W-1:0] lane_off,
    input  logic [LANES*WORD_W-1:0] in_wdata,
    output logic                    req_valid,
    output logic                    req_store,
    output logic [LANES-1:0]        req_mask,
    output logic [LANES*WORD_W-1:0] req_off,
    output logic [LANES*WORD_W-1:0] req_wdata,
    output logic [LANES-1:0]        iss_oob,
    output logic [LANES-1:0]        iss_exec,
    output logic                    auto_done
);
    typedef struct packed {
        logic                    valid;
        logic                    store;
        logic [LANES-1:0]        mask;
        logic [LANES-1:0]        exec;
        logic [LANES-1:0]        oob;
        logic [LANES*WORD_W-1:0] off;
        logic [LANES*WORD_W-1:0] wdata;
    } iss_t;

    iss_t iss_d, iss_q;

    always_comb begin
        iss_d       = iss_q;
        iss_d.valid = in_valid;
        if (in_valid) begin
            iss_d.store = in_store;
            iss_d.exec  = in_exec;
            iss_d.oob   = lane_oob;
            iss_d.mask  = in_exec & ~lane_oob;
            iss_d.off   = lane_off;
            iss_d.wdata = in_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign req_valid = iss_q.valid && (|iss_q.mask);
    assign req_store = iss_q.store;
    assign req_mask  = iss_q.mask;
    assign req_off   = iss_q.off;
    assign req_wdata = iss_q.wdata;
    assign iss_oob   = iss_q.oob;
    assign iss_exec  = iss_q.exec;
    assign auto_done = iss_q.valid && !iss_q.store && !(|iss_q.mask);
endmodule

// File: rtl/vbg_writeback.sv
module vbg_writeback
    import vbg_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rsp_valid,
    input  logic [LANES*WORD_W-1:0] rsp_rdata,
    input  logic                    auto_done,
    input  logic [LANES-1:0]        iss_oob,
    input  logic [LANES-1:0]        iss_exec,
    output logic                    wb_valid,
    output logic [LANES-1:0]        wb_en,
    output logic [LANES*WORD_W-1:0] wb_data
);
    typedef struct packed {
        logic                    valid;
        logic [LANES-1:0]        en;
        logic [LANES*WORD_W-1:0] data;
    } wb_t;

    wb_t wb_d, wb_q;
    logic [LANES*WORD_W-1:0] lane_data;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_data[i*WORD_W +: WORD_W] =
            (iss_oob[i] || auto_done) ? '0 : rsp_rdata[i*WORD_W +: WORD_W];
    end

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = rsp_valid || auto_done;
        wb_d.en    = (rsp_valid || auto_done) ? iss_exec : '0;
        if (rsp_valid || auto_done) wb_d.data = lane_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wb_q <= '0;
        else        wb_q <= wb_d;
    end

    assign wb_valid = wb_q.valid;
    assign wb_en    = wb_q.en;
    assign wb_data  = wb_q.data;
endmodule

// File: rtl/vbuf_range_guard.sv
module vbuf_range_guard
    import vbg_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_store,
    input  logic [LANES-1:0]        in_exec,
    input  logic [LANES*WORD_W-1:0] in_voff,
    input  logic [LANES*WORD_W-1:0] in_vidx,
    input  logic [LANES*WORD_W-1:0] in_wdata,
    input  logic [WORD_W-1:0]       in_inst_off,
    input  logic [WORD_W-1:0]       in_scalar_off,
    input  logic [WORD_W-1:0]       in_stride,
    input  logic [WORD_W-1:0]       in_records,
    input  logic                    in_swz_en,
    output logic                    req_valid,
    output logic                    req_store,
    output logic [LANES-1:0]        req_mask,
    output logic [LANES*WORD_W-1:0] req_off,
    output logic [LANES*WORD_W-1:0] req_wdata,
    input  logic                    rsp_valid,
    input  logic [LANES*WORD_W-1:0] rsp_rdata,
    output logic                    wb_valid,
    output logic [LANES-1:0]        wb_en,
    output logic [LANES*WORD_W-1:0] wb_data
);
    logic                    chk_en;
    logic                    limit_neg;
    span_t                   limit;
    logic [LANES-1:0]        lane_oob;
    logic [LANES*WORD_W-1:0] lane_off;
    logic [LANES-1:0]        iss_oob;
    logic [LANES-1:0]        iss_exec;
    logic                    auto_done;

    // Shared limit: records minus scalar offset, flagged when negative (R2, R4)
    always_comb begin
        chk_en    = (in_stride == '0) || !in_swz_en;
        limit_neg = in_scalar_off > in_records;
        limit     = span_t'(in_records - in_scalar_off);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vbg_lane_check u_chk (
            .voff      (in_voff[i*WORD_W +: WORD_W]),
            .vidx      (in_vidx[i*WORD_W +: WORD_W]),
            .inst_off  (in_inst_off),
            .stride    (in_stride),
            .limit     (limit),
            .limit_neg (limit_neg),
            .chk_en    (chk_en),
            .oob       (lane_oob[i]),
            .reach_lo  (lane_off[i*WORD_W +: WORD_W])
        );
    end

    vbg_issue_stage #(.LANES(LANES)) u_issue (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_store  (in_store),
        .in_exec   (in_exec),
        .lane_oob  (lane_oob),
        .lane_off  (lane_off),
        .in_wdata  (in_wdata),
        .req_valid (req_valid),
        .req_store (req_store),
        .req_mask  (req_mask),
        .req_off   (req_off),
        .req_wdata (req_wdata),
        .iss_oob   (iss_oob),
        .iss_exec  (iss_exec),
        .auto_done (auto_done)
    );

    vbg_writeback #(.LANES(LANES)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .auto_done (auto_done),
        .iss_oob   (iss_oob),
        .iss_exec  (iss_exec),
        .wb_valid  (wb_valid),
        .wb_en     (wb_en),
        .wb_data   (wb_data)
    );
endmodule

// File: rtl/vbg_checker.sv
module vbg_checker
    import vbg_pkg::*;
#(
    parameter int unsigned LANES = 64
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic [LANES-1:0]        in_exec,
    input logic [WORD_W-1:0]       in_scalar_off,
    input logic [WORD_W-1:0]       in_records,
    input logic [WORD_W-1:0]       in_stride,
    input logic                    in_swz_en,
    input logic                    req_valid,
    input logic [LANES-1:0]        req_mask,
    input logic                    wb_valid,
    input logic [LANES-1:0]        wb_en,
    input logic [LANES*WORD_W-1:0] wb_data,
    input logic [LANES-1:0]        iss_oob,
    input logic [LANES-1:0]        iss_exec,
    input logic                    auto_done
);
    logic [LANES-1:0] lane_zero;
    for (genvar i = 0; i < LANES; i++) begin : g_z
        assign lane_zero[i] = (wb_data[i*WORD_W +: WORD_W] == '0);
    end

    a_r1_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(in_valid));
    a_r1_mask_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((req_mask & ~$past(in_exec)) == '0));
    a_r5_no_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_mask != '0));
    a_r4_scalar_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_scalar_off > in_records) && ((in_stride == '0) || !in_swz_en))
        |=> !req_valid);
    a_r6_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ((wb_en & $past(iss_oob) & ~lane_zero) == '0));
    a_r7_en_exec: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_en == $past(iss_exec)));
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> (wb_en == '0));
    a_r8_self_complete: assert property (@(posedge clk) disable iff (!rst_n)
        auto_done |=> wb_valid);
endmodule

bind vbuf_range_guard vbg_checker #(.LANES(LANES)) u_vbg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_exec       (in_exec),
    .in_scalar_off (in_scalar_off),
    .in_records    (in_records),
    .in_stride     (in_stride),
    .in_swz_en     (in_swz_en),
    .req_valid     (req_valid),
    .req_mask      (req_mask),
    .wb_valid      (wb_valid),
    .wb_en         (wb_en),
    .wb_data       (wb_data),
    .iss_oob       (iss_oob),
    .iss_exec      (iss_exec),
    .auto_done     (auto_done)
);

// File: tb/vbuf_range_guard_bench.sv
module vbuf_range_guard_bench;
    localparam int L = 8;

    logic clk = 0;
    logic rst_n = 0;
    logic in_valid = 0, in_store = 0, in_swz_en = 0;
    logic [L-1:0] in_exec = '0;
    logic [L*32-1:0] in_voff = '0, in_vidx = '0, in_wdata = '0;
    logic [31:0] in_inst_off = 0, in_scalar_off = 0, in_stride = 0, in_records = 0;
    logic req_valid, req_store;
    logic [L-1:0] req_mask;
    logic [L*32-1:0] req_off, req_wdata;
    logic rsp_valid = 0;
    logic [L*32-1:0] rsp_rdata = '0;
    logic wb_valid;
    logic [L-1:0] wb_en;
    logic [L*32-1:0] wb_data;

    int tests = 0, fails = 0;

    always #5 clk = ~clk;

    vbuf_range_guard #(.LANES(L)) u_vbuf_range_guard (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic lane_out(input logic [31:0] voff, input logic [31:0] idx,
                                      input logic [31:0] inst, input logic [31:0] sc,
                                      input logic [31:0] st, input logic [31:0] rec,
                                      input logic swz);
        longint unsigned reach;
        if (!(st == 0 || !swz)) return 1'b0;
        if (sc > rec) return 1'b1;
        reach = longint'(voff) + longint'(inst) + longint'(st) * longint'(idx);
        return reach >= longint'(rec - sc);
    endfunction

    function automatic logic [31:0] reach32(input logic [31:0] voff, input logic [31:0] idx,
                                            input logic [31:0] inst, input logic [31:0] st);
        return voff + inst + st * idx;
    endfunction

    // Present in_* as set up by caller, then check request and writeback.
    task automatic run_op();
        logic [L-1:0] oob, exp_mask;
        logic [L*32-1:0] rd;
        for (int i = 0; i < L; i++)
            oob[i] = lane_out(in_voff[i*32+:32], in_vidx[i*32+:32], in_inst_off,
                              in_scalar_off, in_stride, in_records, in_swz_en);
        exp_mask = in_exec & ~oob;
        in_valid = 1;
        @(posedge clk); #1;
        in_valid = 0;
        check("R5 req_valid", 64'(req_valid), 64'(exp_mask != 0));
        if (exp_mask != 0) begin
            check("R1 req_mask", 64'(req_mask), 64'(exp_mask));
            check("R1 req_store", 64'(req_store), 64'(in_store));
            for (int i = 0; i < L; i++) if (exp_mask[i]) begin
                check("R10 req_off", 64'(req_off[i*32+:32]),
                      64'(reach32(in_voff[i*32+:32], in_vidx[i*32+:32], in_inst_off, in_stride)));
                check("R10 req_wdata", 64'(req_wdata[i*32+:32]), 64'(in_wdata[i*32+:32]));
            end
        end
        if (in_store) begin
            check("R7 store no wb", 64'(wb_valid), 64'd0);
            @(posedge clk); #1;
            check("R7 store no wb later", 64'(wb_valid), 64'd0);
            return;
        end
        for (int i = 0; i < L; i++) rd[i*32+:32] = $urandom;
        if (exp_mask != 0) begin
            rsp_rdata = rd;
            rsp_valid = 1;
            @(posedge clk); #1;
            rsp_valid = 0;
        end else begin
            @(posedge clk); #1;  // R8: writeback completes without a response
        end
        check(exp_mask != 0 ? "R6 wb_valid" : "R8 wb_valid self", 64'(wb_valid), 64'd1);
        check("R7 wb_en", 64'(wb_en), 64'(in_exec));
        for (int i = 0; i < L; i++) if (in_exec[i])
            check(oob[i] ? "R6 oob zero" : "R6 data", 64'(wb_data[i*32+:32]),
                  oob[i] ? 64'd0 : 64'(rd[i*32+:32]));
        @(posedge clk); #1;
        check("R7 wb idle", 64'({wb_valid, wb_en}), 64'd0);
    endtask

    task automatic set_lanes(input logic [31:0] vo_base, input logic [31:0] vo_step,
                             input logic [31:0] idx_base);
        for (int i = 0; i < L; i++) begin
            in_voff[i*32+:32]  = vo_base + vo_step * i;
            in_vidx[i*32+:32]  = idx_base + i;
            in_wdata[i*32+:32] = $urandom;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        check("R9 reset req", 64'(req_valid), 64'd0);
        check("R9 reset wb", 64'(wb_valid), 64'd0);
        rst_n = 1;
        @(posedge clk); #1;
        check("R9 after reset", 64'({req_valid, wb_valid}), 64'd0);

        // R2 boundary: limit = 100-20 = 80; lane voff = 76..83 step 1, inst 0
        in_store = 0; in_exec = '1; in_stride = 0; in_swz_en = 0;
        in_records = 100; in_scalar_off = 20; in_inst_off = 0;
        set_lanes(76, 1, 0);
        run_op();
        // R2 with stride: reach = voff + 4*idx + inst
        in_stride = 4; in_swz_en = 0; in_inst_off = 3;
        set_lanes(10, 2, 5);
        run_op();
        // R3: stride nonzero with swizzle: never out of range even past end
        in_swz_en = 1; in_records = 4;
        set_lanes(1000, 1, 0);
        run_op();
        // R4: scalar offset beyond records, store
        in_store = 1; in_stride = 0; in_swz_en = 1; in_records = 10; in_scalar_off = 11;
        set_lanes(0, 0, 0);
        run_op();
        // R8: load with all lanes out, partial exec
        in_store = 0; in_exec = 8'b1010_0110;
        run_op();
        // R7: exec all clear
        in_exec = '0; in_scalar_off = 0; in_records = 1000;
        run_op();
        // R5: store straddling the edge
        in_store = 1; in_exec = '1; in_records = 50; in_scalar_off = 10;
        set_lanes(36, 1, 0);
        run_op();

        for (int n = 0; n < 400; n++) begin
            in_store      = $urandom_range(0, 1);
            in_exec       = L'($urandom);
            in_stride     = ($urandom_range(0, 2) == 0) ? 0 : $urandom_range(1, 8);
            in_swz_en     = $urandom_range(0, 1);
            in_records    = $urandom_range(0, 200);
            in_scalar_off = $urandom_range(0, 220);
            in_inst_off   = $urandom_range(0, 40);
            for (int i = 0; i < L; i++) begin
                in_voff[i*32+:32]  = $urandom_range(0, 150);
                in_vidx[i*32+:32]  = $urandom_range(0, 20);
                in_wdata[i*32+:32] = $urandom;
            end
            run_op();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule